// File: doc/BRIEF.md
# Wrapping Binary64 to Signed 32-bit Integer Converter

This block turns an IEEE 754 binary64 operand into a signed 32-bit integer. It always truncates toward zero. When the value does not fit, it does not clamp to the nearest limit. It keeps the low 32 bits of the exact integer in two's complement, which is the result of arithmetic modulo 2^32. The 32-bit value is then sign-extended to an integer register width `XLEN`, which may be 32 or 64.

Infinities and NaNs give zero. Two flags come with each result. `invalid_o` is set for non-finite inputs and for finite inputs whose truncated value lies outside the signed 32-bit range. `inexact_o` is set when a fraction was discarded and the conversion was not invalid.

The block has one register stage. A conversion presented with `valid_i` appears one clock later with `valid_o`. The outputs keep their last values while no new operand arrives.

Top module: `f64_mod_i32_cvt`

## Requirements
- R1: A finite input with magnitude in [1, 2^31) gives its value truncated toward zero. The fraction is dropped, so 1.5 gives 1, -2.5 gives -2 and 0.75 gives 0.
- R2: For large finite inputs, result bits 31:0 are the low 32 bits of the exact truncated two's-complement integer. This means 2^31 gives 0x80000000, 2^32 gives 0. Any input with unbiased exponent 84 or more also gives 0.
- R3: Result bits XLEN-1:32 are copies of result bit 31.
- R4: Positive infinity, negative infinity, quiet NaN and signaling NaN give a result of 0, with invalid set and inexact clear. An input is non-finite when its exponent field (bits 62:52) is all ones.
- R5: A finite input is invalid when its truncated magnitude exceeds 2^31-1 for a positive sign, or exceeds 2^31 for a negative sign (sign is bit 63). For example, -2^31 is valid and 2^31 is invalid.
- R6: Inexact is set only when a finite input has a non-zero fractional part and invalid is clear. Invalid and inexact are never both set.
- R7: Positive zero and negative zero give 0 with no flags. A non-zero subnormal gives 0 with inexact set.
- R8: A result appears on the outputs one clock after the input is presented with valid_i, and valid_o is high for that one cycle. In a cycle without valid_i, valid_o is low the next cycle and the result and both flags keep their values. Reset clears all outputs.
- R9: For a negative in-range input, the result is the two's complement of the truncated magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| operand_i | input | 64 | Binary64 operand |
| valid_o | output | 1 | Result present this cycle |
| result_o | output | XLEN | Sign-extended 32-bit wrapped integer |
| invalid_o | output | 1 | Non-finite or out-of-range input |
| inexact_o | output | 1 | Fraction discarded on a valid conversion |

## Verification
Most of the random operands have an unbiased exponent between -5 and 89. This range covers the fraction-only, in-range, wrapping and shifted-out regions, and tells apart the right-shift path, the left-shift path and the all-zero path. Some random operands have a fully random exponent, which also produces subnormals, NaNs and infinities.

Directed operands cover the 32-bit boundary values:
- 2^31-1, which is the largest positive value that fits.
- -2^31 and -2^31-0.5, which separate the asymmetric negative limit from an overflow.
- 2^31 and 2^32, which check the wrapping arithmetic.
- 2^83 and 2^84, which check the point where every bit of the integer lies above bit 31.

Signed zeros, the smallest subnormal and both NaN kinds separate the zero, inexact and invalid outcomes.

// File: rtl/f64cvt_pkg.sv
package f64cvt_pkg;
  localparam int EXP_W  = 11;
  localparam int MAN_W  = 52;
  localparam int SIG_W  = MAN_W + 1;
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int INT_W  = 32;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXPU_W = EXP_W + 1;
  localparam int SH_W   = $clog2(MAN_W + INT_W);

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_t;

  typedef struct packed {
    logic              sign;
    logic              special;
    logic              exp_zero;
    logic [EXPU_W-1:0] uexp;
    logic [SIG_W-1:0]  sig;
  } unpacked_t;
endpackage

// File: rtl/f64cvt_unpack.sv
module f64cvt_unpack
  import f64cvt_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output unpacked_t       up_o
);
  fp_t f;
  logic signed [EXPU_W-1:0] ue;

  assign f  = op_i;
  assign ue = $signed({1'b0, f.exp}) - $signed(EXPU_W'(BIAS));

  always_comb begin
    up_o.sign     = f.sign;
    up_o.special  = &f.exp;
    up_o.exp_zero = ~|f.exp;
    up_o.uexp     = ue;
    up_o.sig      = {|f.exp, f.man};
  end
endmodule

// File: rtl/f64cvt_align.sv
module f64cvt_align
  import f64cvt_pkg::*;
(
  input  unpacked_t        up_i,
  output logic [INT_W-1:0] mag_lo_o,
  output logic             frac_nz_o,
  output logic             ge_int_o,
  output logic             eq_top_o
);
  localparam logic signed [EXPU_W-1:0] E_MAN  = EXPU_W'(MAN_W);
  localparam logic signed [EXPU_W-1:0] E_WRAP = EXPU_W'(MAN_W + INT_W);
  localparam logic signed [EXPU_W-1:0] E_INT  = EXPU_W'(INT_W);
  localparam logic signed [EXPU_W-1:0] E_TOP  = EXPU_W'(INT_W - 1);
  localparam logic signed [EXPU_W-1:0] E_ZERO = '0;

  logic signed [EXPU_W-1:0] ue;
  logic [EXPU_W-1:0] rsh_full, lsh_full;
  logic [SH_W-1:0]   rsh, lsh;
  logic [SIG_W-1:0]  int_part, frac_mask;
  logic              normal;

  assign ue        = $signed(up_i.uexp);
  assign normal    = !up_i.special && !up_i.exp_zero;
  assign rsh_full  = E_MAN - ue;
  assign lsh_full  = ue - E_MAN;
  assign rsh       = rsh_full[SH_W-1:0];
  assign lsh       = lsh_full[SH_W-1:0];
  assign int_part  = up_i.sig >> rsh;
  assign frac_mask = ~({SIG_W{1'b1}} << rsh);

  // right shift keeps integer bits; left shift only needs the low word
  always_comb begin
    mag_lo_o  = '0;
    frac_nz_o = 1'b0;
    if (up_i.special) begin
      mag_lo_o = '0;
    end else if (up_i.exp_zero || ue < E_ZERO) begin
      frac_nz_o = |up_i.sig;
    end else if (ue <= E_MAN) begin
      mag_lo_o  = int_part[INT_W-1:0];
      frac_nz_o = |(up_i.sig & frac_mask);
    end else if (ue < E_WRAP) begin
      mag_lo_o = up_i.sig[INT_W-1:0] << lsh;
    end
  end

  assign ge_int_o = normal && (ue >= E_INT);
  assign eq_top_o = normal && (ue == E_TOP);
endmodule

// File: rtl/f64cvt_pack.sv
module f64cvt_pack
  import f64cvt_pkg::*;
(
  input  logic             sign_i,
  input  logic             special_i,
  input  logic [INT_W-1:0] mag_lo_i,
  input  logic             frac_nz_i,
  input  logic             ge_int_i,
  input  logic             eq_top_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] MIN_MAG = {1'b1, {(INT_W-1){1'b0}}};

  logic ovf;

  // magnitude in [2^31, 2^32) fits only as exactly -2^31
  assign ovf = ge_int_i | (eq_top_i & ~(sign_i & (mag_lo_i == MIN_MAG)));

  always_comb begin
    if (special_i)   res_o = '0;
    else if (sign_i) res_o = '0 - mag_lo_i;
    else             res_o = mag_lo_i;
  end

  assign invalid_o = special_i | ovf;
  assign inexact_o = ~special_i & ~ovf & frac_nz_i;
endmodule

// File: rtl/f64_mod_i32_cvt.sv
module f64_mod_i32_cvt
  import f64cvt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [FP_W-1:0] operand_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            invalid_o,
  output logic            inexact_o
);
  unpacked_t        up;
  logic [INT_W-1:0] mag_lo, res_int;
  logic             frac_nz, ge_int, eq_top, inv_d, inx_d;
  logic [XLEN-1:0]  res_x;

  f64cvt_unpack u_unpack (.op_i(operand_i), .up_o(up));

  f64cvt_align u_align (
    .up_i     (up),
    .mag_lo_o (mag_lo),
    .frac_nz_o(frac_nz),
    .ge_int_o (ge_int),
    .eq_top_o (eq_top)
  );

  f64cvt_pack u_pack (
    .sign_i   (up.sign),
    .special_i(up.special),
    .mag_lo_i (mag_lo),
    .frac_nz_i(frac_nz),
    .ge_int_i (ge_int),
    .eq_top_i (eq_top),
    .res_o    (res_int),
    .invalid_o(inv_d),
    .inexact_o(inx_d)
  );

  generate
    if (XLEN > INT_W) begin : g_sext
      assign res_x = {{(XLEN-INT_W){res_int[INT_W-1]}}, res_int};
    end else begin : g_narrow
      assign res_x = res_int[XLEN-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_x;
        invalid_o <= inv_d;
        inexact_o <= inx_d;
      end
    end
  end
endmodule

// File: rtl/f64_mod_i32_cvt_chk.sv
module f64_mod_i32_cvt_chk
  import f64cvt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [FP_W-1:0] operand_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            invalid_o,
  input logic            inexact_o
);
  localparam int WRAP_EXP = BIAS + MAN_W + INT_W;

  logic in_special, in_zero, in_shifted_out;
  assign in_special     = &operand_i[FP_W-2:MAN_W];
  assign in_zero        = ~|operand_i[FP_W-2:0];
  assign in_shifted_out = !in_special && (int'(operand_i[FP_W-2:MAN_W]) >= WRAP_EXP);

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(invalid_o) && $stable(inexact_o)));

  // R3
  sign_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (&result_o[XLEN-1:INT_W-1] || ~|result_o[XLEN-1:INT_W-1]));

  // R4
  special_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_special) |=> (result_o == '0 && invalid_o && !inexact_o));

  // R7
  zero_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_zero) |=> (result_o == '0 && !invalid_o && !inexact_o));

  // R6
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(invalid_o && inexact_o));

  // R2
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_shifted_out) |=> (result_o == '0 && invalid_o));
endmodule

bind f64_mod_i32_cvt f64_mod_i32_cvt_chk #(.XLEN(XLEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .operand_i(operand_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .invalid_o(invalid_o),
  .inexact_o(inexact_o)
);

// File: tb/f64_mod_i32_cvt_bench.sv
module f64_mod_i32_cvt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [63:0]     operand_i = '0;
  logic            valid_o;
  logic [XLEN-1:0] result_o;
  logic            invalid_o;
  logic            inexact_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  f64_mod_i32_cvt #(.XLEN(XLEN)) u_f64_mod_i32_cvt (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .operand_i(operand_i),
    .valid_o(valid_o), .result_o(result_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp, input logic [63:0] op);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s op=%h actual=%h expected=%h", req, what, op, act, exp);
    end
  endtask

  // reference: fixed point with 64 fraction bits, integer part up to 128 bits
  task automatic model(input logic [63:0] op, output logic [31:0] r, output bit inv,
                       output bit inx, output string rtag, output string ftag);
    logic [10:0]  ef;
    logic [52:0]  sig;
    logic [191:0] acc;
    logic [127:0] intp;
    int e;
    ef = op[62:52];
    e  = int'(ef) - 1023;
    sig = {ef != 11'd0, op[51:0]};
    if (ef == 11'h7FF) begin
      r = '0; inv = 1; inx = 0; rtag = "R4"; ftag = "R4";
    end else if (ef == 11'd0) begin
      r = '0; inv = 0; inx = (op[51:0] != '0); rtag = "R7"; ftag = "R7";
    end else if (e < 0) begin
      r = '0; inv = 0; inx = 1; rtag = "R1"; ftag = "R6";
    end else if (e >= 84) begin
      r = '0; inv = 1; inx = 0; rtag = "R2"; ftag = "R5";
    end else begin
      acc  = 192'(sig) << (12 + e);
      intp = acc[191:64];
      inv  = op[63] ? (intp > 128'h8000_0000) : (intp > 128'h7FFF_FFFF);
      r    = op[63] ? (32'd0 - intp[31:0]) : intp[31:0];
      inx  = (|acc[63:0]) && !inv;
      rtag = (e >= 31) ? "R2" : (op[63] ? "R9" : "R1");
      ftag = inv ? "R5" : (inx ? "R6" : rtag);
    end
  endtask

  task automatic apply(input logic [63:0] op);
    logic [31:0] r;
    bit inv, inx;
    string rtag, ftag;
    model(op, r, inv, inx, rtag, ftag);
    @(negedge clk_i);
    valid_i = 1'b1;
    operand_i = op;
    @(negedge clk_i);
    valid_i = 1'b0;
    operand_i = {$urandom, $urandom};
    check(valid_o == 1'b1, "R8", "valid_o", 64'(valid_o), 64'd1, op);
    check(result_o[31:0] == r, rtag, "result low", 64'(result_o[31:0]), 64'(r), op);
    check(result_o[63:32] == {32{r[31]}}, "R3", "result high", 64'(result_o[63:32]),
          64'({32{r[31]}}), op);
    check(invalid_o == inv, ftag, "invalid", 64'(invalid_o), 64'(inv), op);
    check(inexact_o == inx, (inx ? "R6" : ftag), "inexact", 64'(inexact_o), 64'(inx), op);
  endtask

  task automatic idle_check();
    logic [XLEN-1:0] r0;
    logic i0, x0;
    r0 = result_o; i0 = invalid_o; x0 = inexact_o;
    @(negedge clk_i);
    check(valid_o == 1'b0, "R8", "idle valid_o", 64'(valid_o), 64'd0, operand_i);
    check(result_o == r0 && invalid_o == i0 && inexact_o == x0, "R8", "idle hold",
          64'(result_o), 64'(r0), operand_i);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD*3);
    check(valid_o == 0 && result_o == '0 && invalid_o == 0 && inexact_o == 0,
          "R8", "reset state", 64'(result_o), 64'd0, 64'd0);
    rst_ni = 1'b1;
    apply(64'h0000_0000_0000_0000);  // R7 +0
    apply(64'h8000_0000_0000_0000);  // R7 -0
    apply(64'h0000_0000_0000_0001);  // R7 subnormal
    apply(64'h3FF8_0000_0000_0000);  // R1 1.5
    apply(64'hC004_0000_0000_0000);  // R9 -2.5
    apply(64'h3FE8_0000_0000_0000);  // R1 0.75
    apply(64'h41DF_FFFF_FFC0_0000);  // R5 2^31-1
    apply(64'hC1E0_0000_0000_0000);  // R5 -2^31 valid
    apply(64'hC1E0_0000_0010_0000);  // R5 -2^31-0.5 valid inexact
    apply(64'h41E0_0000_0000_0000);  // R2 2^31 wraps
    apply(64'h41F0_0000_0000_0000);  // R2 2^32 wraps to 0
    apply(64'h4520_0000_0000_0001);  // R2 e=83 lsb lands in bit 31
    apply(64'h4530_0000_0000_0000);  // R2 2^84
    apply(64'h7FF0_0000_0000_0000);  // R4 +inf
    apply(64'hFFF0_0000_0000_0000);  // R4 -inf
    apply(64'h7FF8_0000_0000_0000);  // R4 qNaN
    apply(64'h7FF0_0000_0000_0001);  // R4 sNaN
    idle_check();
    for (int i = 0; i < 3000; i++) begin
      logic [10:0] ef;
      logic [63:0] m;
      m  = {$urandom, $urandom};
      ef = ($urandom_range(0, 9) < 8) ? 11'(1018 + $urandom_range(0, 94)) : 11'($urandom);
      apply({m[63], ef, m[51:0]});
      if (i % 97 == 0) idle_check();
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule